// File: doc/BRIEF.md
# Vector Floating-Point Compare Unit

This block runs one vector floating-point compare instruction at a time and produces a packed mask with one bit per element. A start pulse hands it a raw instruction word, the element width, the active length `vl`, the element count `vlmax`, the mask register `v0` and the old destination mask. It then reads operands from the caller-held source vectors and scalar. Elements are compared in index order, one per clock. Lanes at or beyond `vl` but below `vlmax` are cleared. A one-cycle `done_o` pulse marks the end of the instruction.

Half, single and double IEEE-754 values are compared. Equal and not-equal are quiet compares, the four ordering relations are signaling compares, and "ordered" tests that neither operand is NaN. A sticky flag records invalid-operation events. Encodings that cannot be executed produce an `illegal_o` pulse and leave the mask unchanged.

Top module: `vfcmp_unit`

## Requirements
- R1: An instruction is accepted only when all of the following hold. Bits [6:0] are 1010111. Bits [14:12] are 001 (vector-vector) or 101 (vector-scalar). Bits [31:26] are one of the compare codes: eq 011000, ne 011100, lt 011011, le 011001, gt 011101, ge 011111, ord 011010. Gt and ge are allowed only with 101. Any other encoding pulses `illegal_o` in the cycle after start, does not raise `busy_o` or `done_o`, and leaves `vd_o` unchanged.
- R2: The width code `ew_i` is 1 for 16-bit, 2 for 32-bit and 3 for 64-bit elements. Code 0 (8-bit) is treated as an illegal instruction, as in R1.
- R3: Eq is true when both operands are non-NaN and equal, with +0 equal to -0. Ne is the exact complement of eq, so it is true when either operand is NaN.
- R4: Lt, le, gt and ge give `vs2 OP vs1` (or `vs2 OP scalar`) under sign-magnitude ordering, with the two zeros equal. They are false when either operand is NaN.
- R5: Ord is true exactly when neither operand is a NaN.
- R6: Element i of a source vector occupies bits [64*i +: width]. In the vector-scalar form the second operand is the low `width` bits of `scalar_i`. Bits above the element width are ignored.
- R7: When instruction bit 25 is 0 and `v0_i[i]` is 0, for i < `vl_i`, mask bit i keeps its value from `vd_i`. Such an element raises no flag.
- R8: Mask bits i with `vl_i` <= i < `vlmax_i` are written 0. Bits at or above `vlmax_i` keep their `vd_i` value.
- R9: `invalid_o` is sticky until reset. Active lt/le/gt/ge elements set it when any operand is NaN. Active eq/ne/ord elements set it only when an operand is a signaling NaN, meaning a NaN whose top mantissa bit is 0.
- R10: A legal start is followed by exactly `vlmax_i` busy cycles. `done_o` is then seen in cycle `vlmax_i`+1 after the start edge, or in the next cycle when `vlmax_i` is 0. A start while busy is ignored.
- R11: After reset, `busy_o`, `done_o`, `illegal_o`, `invalid_o` and `vd_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| insn_i | input | 32 | Instruction word |
| ew_i | input | 2 | Element width code |
| vl_i | input | $clog2(NELEM+1) | Active element count |
| vlmax_i | input | $clog2(NELEM+1) | Element count to cover, at most NELEM |
| v0_i | input | NELEM | Element mask register |
| vd_i | input | NELEM | Old destination mask |
| vs1_i | input | 64*NELEM | First source vector, held while busy |
| vs2_i | input | 64*NELEM | Second source vector, held while busy |
| scalar_i | input | 64 | Scalar operand |
| vd_o | output | NELEM | Destination mask |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
In a single element cycle, masking and flag raising can meet: an element that is masked off can carry a signaling NaN, or an active element can carry a quiet NaN into a quiet compare. The bench provokes this directly, from reset, with signaling NaNs placed only in masked-off lanes and in tail lanes. Random operands also draw NaNs, zeros and infinities under random masks. The check is that the mask lane keeps its old value and that the sticky flag follows only active elements, compared against a bench model built on signed integer keys.

// File: rtl/vfcmp_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the vector compare unit.
// Assumes: raw 32-bit instruction words and a 2-bit element width code.
package vfcmp_pkg;
    localparam logic [6:0] OPC_VEC = 7'b1010111;
    localparam logic [2:0] F3_VV   = 3'b001;
    localparam logic [2:0] F3_VF   = 3'b101;
    localparam logic [5:0] F6_EQ   = 6'b011000;
    localparam logic [5:0] F6_NE   = 6'b011100;
    localparam logic [5:0] F6_LT   = 6'b011011;
    localparam logic [5:0] F6_LE   = 6'b011001;
    localparam logic [5:0] F6_GT   = 6'b011101;
    localparam logic [5:0] F6_GE   = 6'b011111;
    localparam logic [5:0] F6_ORD  = 6'b011010;
    localparam int         NFMT    = 3;

    typedef enum logic [2:0] {
        CMP_EQ, CMP_NE, CMP_LT, CMP_LE, CMP_GT, CMP_GE, CMP_ORD
    } cmp_op_e;

    typedef enum logic [1:0] {
        EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_64 = 2'd3
    } ew_e;

    typedef struct packed {
        cmp_op_e op;
        logic    unmasked;
        logic    use_scalar;
        logic    legal;
    } dec_t;
endpackage

// File: rtl/vfcmp_decode.sv
`timescale 1ns/1ps
// Instruction decoder: maps an instruction word and width code to a compare
// operation, and flags encodings that cannot run.
// Assumes: purely combinational; the caller samples it on start.
module vfcmp_decode
    import vfcmp_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic [1:0]  ew_i,
    output dec_t        dec_o
);
    logic       known;
    logic       form_ok;
    logic       scalar_form;
    cmp_op_e    op;

    // Purpose: decode the operation code, the form and legality.
    always_comb begin
        known = 1'b1;
        op    = CMP_EQ;
        unique case (insn_i[31:26])
            F6_EQ:   op = CMP_EQ;
            F6_NE:   op = CMP_NE;
            F6_LT:   op = CMP_LT;
            F6_LE:   op = CMP_LE;
            F6_GT:   op = CMP_GT;
            F6_GE:   op = CMP_GE;
            F6_ORD:  op = CMP_ORD;
            default: known = 1'b0;
        endcase
        scalar_form = (insn_i[14:12] == F3_VF);
        form_ok     = scalar_form || (insn_i[14:12] == F3_VV);
        dec_o.op         = op;
        dec_o.unmasked   = insn_i[25];
        dec_o.use_scalar = scalar_form;
        dec_o.legal      = (insn_i[6:0] == OPC_VEC) && form_ok && known &&
                           !((op == CMP_GT || op == CMP_GE) && !scalar_form) &&
                           (ew_e'(ew_i) != EW_8);
    end
endmodule

// File: rtl/vfcmp_elem.sv
`timescale 1ns/1ps
// One-element IEEE-754 comparator for half, single and double values.
// Assumes: operands sit in the low bits of 64-bit words; upper bits ignored.
module vfcmp_elem
    import vfcmp_pkg::*;
(
    input  ew_e         ew_i,
    input  cmp_op_e     op_i,
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    output logic        res_o,
    output logic        inv_o
);
    logic [NFMT-1:0] sa_v, sb_v, na_v, nb_v, qa_v, qb_v;
    logic [62:0]     ma_v [NFMT];
    logic [62:0]     mb_v [NFMT];

    // One field extractor per supported format.
    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int W  = 16 << g;
        localparam int EB = (g == 0) ? 5 : ((g == 1) ? 8 : 11);
        localparam int MB = W - 1 - EB;
        assign sa_v[g] = a_i[W-1];
        assign sb_v[g] = b_i[W-1];
        assign ma_v[g] = 63'(a_i[W-2:0]);
        assign mb_v[g] = 63'(b_i[W-2:0]);
        assign na_v[g] = (&a_i[W-2 -: EB]) && (|a_i[MB-1:0]);
        assign nb_v[g] = (&b_i[W-2 -: EB]) && (|b_i[MB-1:0]);
        assign qa_v[g] = a_i[MB-1];
        assign qb_v[g] = b_i[MB-1];
    end

    logic        sa, sb, na, nb, qa, qb;
    logic [62:0] ma, mb;
    logic        any_nan, any_snan, both_zero, eq, lt;

    // Purpose: pick the fields of the active format.
    always_comb begin
        int k;
        unique case (ew_i)
            EW_32:   k = 1;
            EW_64:   k = 2;
            default: k = 0;
        endcase
        sa = sa_v[k]; sb = sb_v[k]; na = na_v[k]; nb = nb_v[k];
        qa = qa_v[k]; qb = qb_v[k]; ma = ma_v[k]; mb = mb_v[k];
    end

    // Purpose: sign-magnitude relation and the per-operation result and flag.
    always_comb begin
        any_nan   = na || nb;
        any_snan  = (na && !qa) || (nb && !qb);
        both_zero = (ma == '0) && (mb == '0);
        eq        = both_zero || ((sa == sb) && (ma == mb));
        lt        = !both_zero && ((sa && !sb) ||
                                   (!sa && !sb && (ma < mb)) ||
                                   (sa && sb && (ma > mb)));
        res_o = 1'b0;
        inv_o = any_nan;
        unique case (op_i)
            CMP_EQ:  begin res_o = !any_nan && eq;         inv_o = any_snan; end
            CMP_NE:  begin res_o = any_nan || !eq;         inv_o = any_snan; end
            CMP_ORD: begin res_o = !any_nan;               inv_o = any_snan; end
            CMP_LT:  res_o = !any_nan && lt;
            CMP_LE:  res_o = !any_nan && (lt || eq);
            CMP_GT:  res_o = !any_nan && !lt && !eq;
            CMP_GE:  res_o = !any_nan && !lt;
            default: res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vfcmp_ctrl.sv
`timescale 1ns/1ps
// Sequencer: walks the element index from 0 to the count minus one, one
// element per clock, and pulses done after the last one.
// Assumes: accept_i is only high while idle.
module vfcmp_ctrl #(
    parameter int NELEM = 8,
    localparam int CW = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [CW-1:0] count_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] idx_o
);
    logic [CW-1:0] lim_q;

    // Purpose: run the index counter and form the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
            lim_q  <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (accept_i) begin
                    idx_o <= '0;
                    lim_q <= count_i;
                    if (count_i == '0) done_o <= 1'b1;
                    else               busy_o <= 1'b1;
                end
            end else if (idx_o == lim_q - 1'b1) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end else begin
                idx_o <= idx_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vfcmp_unit.sv
`timescale 1ns/1ps
// Vector floating-point compare unit: decodes an instruction on start, then
// compares one element per cycle and writes one mask bit per element.
// Assumes: vs1_i and vs2_i stay stable while busy_o is high; vlmax_i <= NELEM
// and vl_i <= vlmax_i.
module vfcmp_unit
    import vfcmp_pkg::*;
#(
    parameter int NELEM = 8,
    localparam int CW = $clog2(NELEM + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [31:0]        insn_i,
    input  logic [1:0]         ew_i,
    input  logic [CW-1:0]      vl_i,
    input  logic [CW-1:0]      vlmax_i,
    input  logic [NELEM-1:0]   v0_i,
    input  logic [NELEM-1:0]   vd_i,
    input  logic [64*NELEM-1:0] vs1_i,
    input  logic [64*NELEM-1:0] vs2_i,
    input  logic [63:0]        scalar_i,
    output logic [NELEM-1:0]   vd_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               illegal_o,
    output logic               invalid_o
);
    dec_t             dec;
    logic             accept;
    logic [CW-1:0]    idx;
    cmp_op_e          op_q;
    ew_e              ew_q;
    logic             unmasked_q, scalar_q;
    logic [CW-1:0]    vl_q;
    logic [NELEM-1:0] v0_q;
    logic [63:0]      scal_q;
    logic [63:0]      opa, opb;
    logic             res, inv;

    vfcmp_decode u_dec (.insn_i(insn_i), .ew_i(ew_i), .dec_o(dec));

    assign accept = start_i && !busy_o && dec.legal;

    vfcmp_ctrl #(.NELEM(NELEM)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .count_i(vlmax_i),
        .busy_o(busy_o), .done_o(done_o), .idx_o(idx)
    );

    // Purpose: select the current element's operands.
    always_comb begin
        opa = vs2_i[64*int'(idx) +: 64];
        opb = scalar_q ? scal_q : vs1_i[64*int'(idx) +: 64];
    end

    vfcmp_elem u_elem (
        .ew_i(ew_q), .op_i(op_q), .a_i(opa), .b_i(opb),
        .res_o(res), .inv_o(inv)
    );

    // Purpose: capture the instruction context on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= CMP_EQ;
            ew_q       <= EW_16;
            unmasked_q <= 1'b1;
            scalar_q   <= 1'b0;
            vl_q       <= '0;
            v0_q       <= '0;
            scal_q     <= '0;
        end else if (accept) begin
            op_q       <= dec.op;
            ew_q       <= ew_e'(ew_i);
            unmasked_q <= dec.unmasked;
            scalar_q   <= dec.use_scalar;
            vl_q       <= vl_i;
            v0_q       <= v0_i;
            scal_q     <= scalar_i;
        end
    end

    // Purpose: update the mask, the sticky flag and the illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_o      <= '0;
            invalid_o <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            illegal_o <= start_i && !busy_o && !dec.legal;
            if (accept) begin
                vd_o <= vd_i;
            end else if (busy_o) begin
                if (idx < vl_q) begin
                    if (unmasked_q || v0_q[idx]) begin
                        vd_o[idx] <= res;
                        invalid_o <= invalid_o | inv;
                    end
                end else begin
                    vd_o[idx] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/vfcmp_unit_chk.sv
`timescale 1ns/1ps
// Property checker for vfcmp_unit, bound to every instance.
// Assumes: vl_i and vlmax_i are held until done_o has been seen.
module vfcmp_unit_chk #(
    parameter int NELEM = 8,
    localparam int CW = $clog2(NELEM + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CW-1:0]    vl_i,
    input logic [CW-1:0]    vlmax_i,
    input logic [NELEM-1:0] vd_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             illegal_o,
    input logic             invalid_o
);
    logic [NELEM-1:0] tail_m;

    // Purpose: lanes that must be cleared at the end of a run.
    always_comb begin
        for (int i = 0; i < NELEM; i++)
            tail_m[i] = (i >= int'(vl_i)) && (i < int'(vlmax_i));
    end

    p_illegal_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(vd_o));
    p_illegal_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!busy_o && !done_o));
    p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((vd_o & tail_m) == '0));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |=> invalid_o);
    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_reset_state_r11: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !illegal_o && !invalid_o && vd_o == '0));
endmodule

bind vfcmp_unit vfcmp_unit_chk #(.NELEM(NELEM)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .vlmax_i(vlmax_i), .vd_o(vd_o), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o), .invalid_o(invalid_o)
);

// File: tb/vfcmp_unit_bench.sv
`timescale 1ns/1ps
module vfcmp_unit_bench;
    localparam int NELEM = 8;
    localparam int CW = $clog2(NELEM + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [31:0]        insn_i = '0;
    logic [1:0]         ew_i = 2'd1;
    logic [CW-1:0]      vl_i = '0;
    logic [CW-1:0]      vlmax_i = '0;
    logic [NELEM-1:0]   v0_i = '0;
    logic [NELEM-1:0]   vd_i = '0;
    logic [64*NELEM-1:0] vs1_i = '0;
    logic [64*NELEM-1:0] vs2_i = '0;
    logic [63:0]        scalar_i = '0;
    logic [NELEM-1:0]   vd_o;
    logic               busy_o, done_o, illegal_o, invalid_o;

    int n_tests = 0;
    int n_fail = 0;
    logic [NELEM-1:0] last_vd = '0;
    bit exp_inv = 1'b0;

    localparam logic [5:0] F6 [7] = '{6'b011000, 6'b011100, 6'b011011,
                                      6'b011001, 6'b011101, 6'b011111, 6'b011010};

    vfcmp_unit #(.NELEM(NELEM)) u_vfcmp_unit (.*);

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int wid(input logic [1:0] ew);
        return 16 << (ew - 1);
    endfunction
    function automatic int ebits(input int w);
        return (w == 16) ? 5 : ((w == 32) ? 8 : 11);
    endfunction
    function automatic bit is_nan(input logic [63:0] x, input int w);
        int mb = w - 1 - ebits(w);
        logic [63:0] e = (x >> mb) & ((64'd1 << ebits(w)) - 1);
        return (e == (64'd1 << ebits(w)) - 1) && ((x & ((64'd1 << mb) - 1)) != 0);
    endfunction
    function automatic bit is_snan(input logic [63:0] x, input int w);
        return is_nan(x, w) && !x[w - 2 - ebits(w)];
    endfunction
    function automatic longint key(input logic [63:0] x, input int w);
        logic [63:0] mag = x & ((64'd1 << (w - 1)) - 1);
        return x[w-1] ? -longint'(mag) : longint'(mag);
    endfunction

    // Reference result and flag of one element: a OP b.
    function automatic void ref_elem(input int op, input int w, input logic [63:0] a,
                                     input logic [63:0] b, output bit r, output bit inv);
        bit nan = is_nan(a, w) || is_nan(b, w);
        bit sn = is_snan(a, w) || is_snan(b, w);
        longint ka = key(a, w);
        longint kb = key(b, w);
        case (op)
            0: begin r = !nan && ka == kb; inv = sn; end
            1: begin r = nan || ka != kb;  inv = sn; end
            2: begin r = !nan && ka < kb;  inv = nan; end
            3: begin r = !nan && ka <= kb; inv = nan; end
            4: begin r = !nan && ka > kb;  inv = nan; end
            5: begin r = !nan && ka >= kb; inv = nan; end
            default: begin r = !nan; inv = sn; end
        endcase
    endfunction

    function automatic logic [31:0] mk_insn(input int op, input bit vf, input bit vm);
        return {F6[op], vm, 5'd2, 5'd1, vf ? 3'b101 : 3'b001, 5'd3, 7'b1010111};
    endfunction

    function automatic logic [63:0] gen_val(input int w, input logic [63:0] other);
        logic [63:0] r = {$urandom, $urandom};
        logic [63:0] g = {$urandom, $urandom};
        int mb = w - 1 - ebits(w);
        logic [63:0] em = ((64'd1 << ebits(w)) - 1) << mb;
        logic [63:0] lm = (w == 64) ? '1 : ((64'd1 << w) - 1);
        logic [63:0] v;
        case ($urandom % 8)
            0: v = r;
            1: v = other;
            2: v = 64'd0;
            3: v = 64'd1 << (w - 1);
            4: v = em | (64'd1 << (mb - 1)) | (r & ((64'd1 << (mb - 1)) - 1));
            5: v = em | 64'd1 | (r & ((64'd1 << (mb - 1)) - 1));
            6: v = em | (r[0] ? (64'd1 << (w - 1)) : 64'd0);
            default: v = other ^ (64'd1 << (w - 1));
        endcase
        return (v & lm) | (g & ~lm);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        last_vd = '0;
        exp_inv = 1'b0;
    endtask

    // Issue one instruction and check every visible effect of it.
    task automatic run_op(input string tag, input logic [31:0] insn, input logic [1:0] ew,
                          input int vl, input int vlmax, input logic [NELEM-1:0] v0,
                          input logic [NELEM-1:0] vd, input bit mid_start);
        bit legal;
        int op;
        int w;
        logic [NELEM-1:0] evd;
        bit r, iv;
        int cyc;
        bit saw_ill;
        @(negedge clk);
        insn_i = insn; ew_i = ew; vl_i = CW'(vl); vlmax_i = CW'(vlmax);
        v0_i = v0; vd_i = vd; start_i = 1'b1;
        op = -1;
        for (int k = 0; k < 7; k++) if (insn[31:26] == F6[k]) op = k;
        legal = (insn[6:0] == 7'b1010111) && (op >= 0) && (ew != 2'd0) &&
                (insn[14:12] == 3'b101 || (insn[14:12] == 3'b001 && op != 4 && op != 5));
        evd = last_vd;
        if (legal) begin
            w = wid(ew);
            evd = vd;
            for (int i = 0; i < vlmax; i++) begin
                if (i >= vl) evd[i] = 1'b0;
                else if (insn[25] || v0[i]) begin
                    ref_elem(op, w, vs2_i[64*i +: 64],
                             insn[14] ? scalar_i : vs1_i[64*i +: 64], r, iv);
                    evd[i] = r;
                    exp_inv = exp_inv | iv;
                end
            end
        end
        @(negedge clk);
        start_i = mid_start;
        if (mid_start) insn_i = 32'hFFFF_FFFF;
        cyc = 1;
        saw_ill = illegal_o;
        if (!legal) begin
            chk(illegal_o == 1'b1 && !busy_o && !done_o, {tag, " illegal pulse R1"},
                {busy_o, done_o, illegal_o}, 3'b001);
        end else begin
            while (!done_o && cyc < NELEM + 4) begin
                @(negedge clk);
                start_i = 1'b0;
                saw_ill = saw_ill | illegal_o;
                cyc++;
            end
            chk(cyc == vlmax + 1, {tag, " done latency R10"}, cyc, vlmax + 1);
            chk(!saw_ill, {tag, " no illegal on legal run R10"}, saw_ill, 0);
        end
        start_i = 1'b0;
        chk(vd_o == evd, {tag, " mask"}, vd_o, evd);
        chk(invalid_o == exp_inv, {tag, " invalid flag R9"}, invalid_o, exp_inv);
        last_vd = vd_o;
    endtask

    function automatic logic [63:0] hv(input logic [15:0] x);
        return {48'hABCD_0123_4567, x};
    endfunction

    initial begin
        logic [63:0] a, b;
        void'($urandom(32'd1234));
        do_reset();
        @(negedge clk);
        chk(!busy_o && !done_o && !illegal_o && !invalid_o && vd_o == '0,
            "R11 reset state", {busy_o, done_o, illegal_o, invalid_o, vd_o}, 0);

        // R3: half eq/ne with +0/-0, equal values and a quiet NaN.
        vs2_i[0 +: 64] = hv(16'h0000); vs1_i[0 +: 64]  = hv(16'h8000);
        vs2_i[64 +: 64] = hv(16'h3C00); vs1_i[64 +: 64] = hv(16'h3C00);
        vs2_i[128 +: 64] = hv(16'h7E00); vs1_i[128 +: 64] = hv(16'h7E00);
        vs2_i[192 +: 64] = hv(16'h3C00); vs1_i[192 +: 64] = hv(16'h4000);
        run_op("R3 eq zeros", mk_insn(0, 0, 1), 2'd1, 4, 4, '0, '1, 0);
        run_op("R3 ne nan", mk_insn(1, 0, 1), 2'd1, 4, 4, '0, '0, 0);

        // R4: single lt/le with mixed signs.
        vs2_i[0 +: 64] = 64'hBF80_0000; vs1_i[0 +: 64] = 64'h3F80_0000;
        vs2_i[64 +: 64] = 64'hC000_0000; vs1_i[64 +: 64] = 64'hBF80_0000;
        vs2_i[128 +: 64] = 64'h4000_0000; vs1_i[128 +: 64] = 64'h4000_0000;
        run_op("R4 lt", mk_insn(2, 0, 1), 2'd2, 3, 3, '0, '0, 0);
        run_op("R4 le", mk_insn(3, 0, 1), 2'd2, 3, 3, '0, '0, 0);

        // R6: gt against a scalar whose upper bits are garbage.
        scalar_i = 64'hDEAD_BEEF_4000_0000;
        vs2_i[0 +: 64] = 64'h4040_0000; vs2_i[64 +: 64] = 64'h3F80_0000;
        run_op("R6 gt scalar", mk_insn(4, 1, 1), 2'd2, 2, 2, '0, '0, 0);

        // R5: ordered on doubles with a signaling NaN sets the flag.
        do_reset();
        vs2_i[0 +: 64] = 64'h7FF0_0000_0000_0001; vs1_i[0 +: 64] = 64'h3FF0_0000_0000_0000;
        vs2_i[64 +: 64] = 64'h4000_0000_0000_0000; vs1_i[64 +: 64] = 64'hFFF0_0000_0000_0000;
        run_op("R5 ord", mk_insn(6, 0, 1), 2'd3, 2, 2, '0, '0, 0);

        // R7/R9: signaling NaNs only in masked-off and tail lanes: no flag.
        do_reset();
        vs2_i[0 +: 64] = hv(16'h7C01); vs1_i[0 +: 64] = hv(16'h3C00);
        vs2_i[64 +: 64] = hv(16'h3C00); vs1_i[64 +: 64] = hv(16'h3C00);
        vs2_i[128 +: 64] = hv(16'h7C01); vs1_i[128 +: 64] = hv(16'h7C01);
        run_op("R7 masked snan", mk_insn(2, 0, 0), 2'd1, 2, 4, 8'b0000_0010, 8'b1111_0101, 0);

        // R9: quiet NaN in quiet compare leaves flag clear; in lt it sets it.
        vs2_i[0 +: 64] = hv(16'h7E00); vs1_i[0 +: 64] = hv(16'h3C00);
        run_op("R9 eq qnan", mk_insn(0, 0, 1), 2'd1, 1, 1, '0, '0, 0);
        run_op("R9 lt qnan", mk_insn(2, 0, 1), 2'd1, 1, 1, '0, '0, 0);

        // R8: tail lanes cleared, lanes at or above vlmax kept.
        run_op("R8 tail", mk_insn(0, 1, 1), 2'd2, 2, 6, '0, '1, 0);
        run_op("R8 zero length", mk_insn(0, 1, 1), 2'd2, 0, 0, '0, 8'hA5, 0);

        // R1/R2: illegal encodings keep the mask.
        run_op("R1 gt vector form", mk_insn(4, 0, 1), 2'd2, 4, 4, '0, 8'h0F, 0);
        run_op("R1 bad opcode", mk_insn(0, 0, 1) ^ 32'h1, 2'd2, 4, 4, '0, 8'h0F, 0);
        run_op("R2 byte width", mk_insn(0, 0, 1), 2'd0, 4, 4, '0, 8'h0F, 0);

        // R10: a start while busy is ignored.
        run_op("R10 start busy", mk_insn(1, 0, 1), 2'd2, 5, 8, '0, '0, 1);

        // Random mix: tag by compare group.
        for (int t = 0; t < 400; t++) begin
            int op = $urandom % 7;
            logic [1:0] ew = ($urandom % 16 == 0) ? 2'd0 : 2'($urandom % 3 + 1);
            int w = (ew == 0) ? 16 : wid(ew);
            int vmx = $urandom % (NELEM + 1);
            int vl = (vmx == 0) ? 0 : $urandom % (vmx + 1);
            string tg = (op < 2) ? "R3 rnd" : ((op < 6) ? "R4 rnd" : "R5 rnd");
            for (int i = 0; i < NELEM; i++) begin
                a = gen_val(w, {$urandom, $urandom});
                b = gen_val(w, a);
                vs2_i[64*i +: 64] = a;
                vs1_i[64*i +: 64] = b;
            end
            scalar_i = gen_val(w, vs2_i[63:0]);
            if (t == 200) do_reset();
            run_op(tg, mk_insn(op, $urandom % 2, $urandom % 2), ew, vl, vmx,
                   NELEM'($urandom), NELEM'($urandom), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule